// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block converts one raw register operand into the unpacked form used inside a floating-point datapath. The operand is presented as four 32-bit words on a single 128-bit input. A type code says how to read it: a 32-bit signed integer, a 64-bit signed integer, or an IEEE binary32, binary64 or binary128 value. The result has a sign bit, a signed unbiased exponent, a 128-bit mantissa whose leading one always sits at bit 114, and a class code. An invalid-operation flag is raised for signalling NaNs.

Denormals and integers are normalised inside the block. A leading-zero count drives a left shift, and the shift amount is taken off the exponent. Signalling NaNs leave the block already quieted, and they can still be told apart by their class. The unit takes one request per `in_valid` pulse and registers every result, which appears with `out_valid` one clock later. The outputs keep their values until the next request.

Top module: `fp_operand_unpack`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high. All result outputs belong to that request and hold their value until the next request.
- R2: Word 0 is `in_op[127:96]`, word 1 is `in_op[95:64]`, word 2 is `in_op[63:32]` and word 3 is `in_op[31:0]`. `out_sign` is always bit 127, whatever the type.
- R3: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN. A zero IEEE value (biased exponent 0, fraction 0) or a zero integer gives class 0, with exponent 0 and mantissa 0.
- R4: In an IEEE value the biased exponent lies just below the sign bit and the fraction just below the exponent. A normal value gives class 1, exponent = biased exponent − bias, and mantissa = 1 at bit 114 with the fraction left-aligned from bit 113 down.
- R5: A denormal IEEE value (biased exponent 0, fraction not 0) gives class 1. The mantissa is shifted left until bit 114 is 1, and the exponent = 1 − bias − shift.
- R6: An infinity (biased exponent all ones, fraction 0) gives class 2, with mantissa 0 and exponent 0.
- R7: A NaN whose fraction MSB is 1 gives class 3. Its mantissa is the left-aligned fraction with bit 113 set, its exponent is 0 and `out_invalid` stays low.
- R8: A NaN whose fraction MSB is 0 gives class 4. Its mantissa is the left-aligned fraction with bit 113 forced to 1, its exponent is 0 and `out_invalid` is high.
- R9: For type 0 the integer is word 0 in two's complement. A nonzero value gives class 1, the magnitude is shifted so its MSB sits at bit 114, and the exponent is that MSB's index within the magnitude.
- R10: For type 1 the integer is {word 0, word 1}, with word 0 as the high half. It is handled as in R9 with a 64-bit magnitude.
- R11: The type codes are 0 int32, 1 int64, 2 binary32 (8-bit exponent, bias 127), 3 binary64 (11, 1023) and 4 binary128 (15, 16383). Codes 5 to 7 give class 0, mantissa 0, exponent 0 and `out_type_err` high. Every valid type gives `out_type_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one cycle per operand |
| in_type | input | 3 | Operand type code |
| in_op | input | 128 | Operand words 0..3, word 0 in the top bits |
| out_valid | output | 1 | Result strobe |
| out_sign | output | 1 | Sign of the operand |
| out_exp | output | 18 | Signed unbiased exponent |
| out_mant | output | 128 | Mantissa, leading one at bit 114 |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Invalid-operation flag (signalling NaN) |
| out_type_err | output | 1 | Unsupported type code |

## Verification
Every result comes from one register stage. All outputs for a request change at the first rising edge after the cycle in which `in_valid` was high, including the normalised mantissa, the class and both flags. The bench drives each request just after a falling edge and compares all six result fields at the following falling edge, half a period after they were captured. Requests are issued back to back so that each one overwrites the last, and after each directed case an idle cycle confirms that `out_valid` falls again.

// File: rtl/fp_unpack_pkg.sv
package fp_unpack_pkg;

  localparam int UP_MANT_W = 128;
  localparam int UP_LEAD   = 114;
  localparam int UP_EXP_W  = 18;

  localparam logic [2:0] CLS_ZERO = 3'd0;
  localparam logic [2:0] CLS_NUM  = 3'd1;
  localparam logic [2:0] CLS_INF  = 3'd2;
  localparam logic [2:0] CLS_QNAN = 3'd3;
  localparam logic [2:0] CLS_SNAN = 3'd4;

  localparam logic [2:0] TY_I32  = 3'd0;
  localparam logic [2:0] TY_I64  = 3'd1;
  localparam logic [2:0] TY_SGL  = 3'd2;
  localparam logic [2:0] TY_DBL  = 3'd3;
  localparam logic [2:0] TY_QUAD = 3'd4;

  // exponent field width per IEEE format slot (0 single, 1 double, 2 quad)
  function automatic int fmt_exp_w(input int slot);
    case (slot)
      0:       return 8;
      1:       return 11;
      default: return 15;
    endcase
  endfunction

  function automatic int fmt_frac_w(input int slot);
    case (slot)
      0:       return 23;
      1:       return 52;
      default: return 112;
    endcase
  endfunction

endpackage

// File: rtl/fp_unpack_ieee.sv
module fp_unpack_ieee #(
  parameter int EXPB   = 8,
  parameter int FRACB  = 23,
  parameter int MANT_W = 128,
  parameter int LEAD   = 114,
  parameter int EXP_W  = 18
) (
  input  logic [EXPB+FRACB-1:0]    body,
  output logic                     exp_zero,
  output logic                     exp_max,
  output logic                     frac_nz,
  output logic                     quiet,
  output logic signed [EXP_W-1:0]  norm_exp,
  output logic signed [EXP_W-1:0]  denorm_exp,
  output logic [MANT_W-1:0]        frac_al
);
  localparam int BIAS = (1 << (EXPB - 1)) - 1;

  logic [EXPB-1:0]  biased;
  logic [FRACB-1:0] frac;

  assign biased     = body[EXPB+FRACB-1 -: EXPB];
  assign frac       = body[FRACB-1:0];
  assign exp_zero   = (biased == '0);
  assign exp_max    = (biased == '1);
  assign frac_nz    = (frac != '0);
  assign quiet      = frac[FRACB-1];
  assign norm_exp   = $signed(EXP_W'(biased)) - $signed(EXP_W'(BIAS));
  assign denorm_exp = $signed(EXP_W'(1)) - $signed(EXP_W'(BIAS));
  assign frac_al    = MANT_W'(frac) << (LEAD - FRACB);
endmodule

// File: rtl/fp_unpack_int.sv
module fp_unpack_int #(
  parameter int MANT_W = 128,
  parameter int LEAD   = 114,
  parameter int EXP_W  = 18
) (
  input  logic [63:0]              words,
  input  logic                     is64,
  output logic                     is_zero,
  output logic [MANT_W-1:0]        mant,
  output logic signed [EXP_W-1:0]  exp_preset
);
  logic [31:0] w_hi;
  logic [31:0] mag32;
  logic [63:0] mag64;

  assign w_hi  = words[63:32];
  assign mag32 = w_hi[31] ? (~w_hi + 32'd1) : w_hi;
  assign mag64 = words[63] ? (~words + 64'd1) : words;

  always_comb begin
    if (is64) begin
      is_zero    = (words == '0);
      mant       = MANT_W'(mag64) << (LEAD - 63);
      exp_preset = EXP_W'(63);
    end else begin
      is_zero    = (w_hi == '0);
      mant       = MANT_W'(mag32) << (LEAD - 31);
      exp_preset = EXP_W'(31);
    end
  end
endmodule

// File: rtl/fp_unpack_norm.sv
module fp_unpack_norm #(
  parameter int MANT_W = 128,
  parameter int LEAD   = 114,
  parameter int EXP_W  = 18
) (
  input  logic [MANT_W-1:0]        mant_in,
  input  logic signed [EXP_W-1:0]  exp_in,
  output logic [MANT_W-1:0]        mant_out,
  output logic signed [EXP_W-1:0]  exp_out,
  output logic [6:0]               shift
);
  // zeros counted from the leading-one position downwards
  function automatic logic [6:0] lead_zeros(input logic [MANT_W-1:0] m);
    logic [6:0] cnt;
    logic       hit;
    cnt = '0;
    hit = 1'b0;
    for (int b = LEAD; b >= 0; b--) begin
      if (!hit) begin
        if (m[b]) hit = 1'b1;
        else      cnt = cnt + 7'd1;
      end
    end
    return cnt;
  endfunction

  assign shift    = lead_zeros(mant_in);
  assign mant_out = mant_in << shift;
  assign exp_out  = exp_in - $signed({{(EXP_W-7){1'b0}}, shift});
endmodule

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
  import fp_unpack_pkg::*;
#(
  parameter int MANT_W = UP_MANT_W,
  parameter int LEAD   = UP_LEAD,
  parameter int EXP_W  = UP_EXP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_type,
  input  logic [127:0]      in_op,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [MANT_W-1:0] out_mant,
  output logic [2:0]        out_class,
  output logic              out_invalid,
  output logic              out_type_err
);
  localparam int NFMT = 3;
  localparam logic [MANT_W-1:0] QBIT = MANT_W'(1) << (LEAD - 1);
  localparam logic [MANT_W-1:0] HBIT = MANT_W'(1) << LEAD;

  // per-format field views
  logic                    f_ez [NFMT];
  logic                    f_em [NFMT];
  logic                    f_nz [NFMT];
  logic                    f_q  [NFMT];
  logic signed [EXP_W-1:0] f_ue [NFMT];
  logic signed [EXP_W-1:0] f_de [NFMT];
  logic [MANT_W-1:0]       f_al [NFMT];

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int EB = fmt_exp_w(g);
    localparam int FB = fmt_frac_w(g);
    fp_unpack_ieee #(
      .EXPB(EB), .FRACB(FB), .MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)
    ) u_fld (
      .body      (in_op[126 -: EB+FB]),
      .exp_zero  (f_ez[g]),
      .exp_max   (f_em[g]),
      .frac_nz   (f_nz[g]),
      .quiet     (f_q[g]),
      .norm_exp  (f_ue[g]),
      .denorm_exp(f_de[g]),
      .frac_al   (f_al[g])
    );
  end

  logic                    i_zero;
  logic [MANT_W-1:0]       i_mant;
  logic signed [EXP_W-1:0] i_exp;

  fp_unpack_int #(.MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)) u_int (
    .words     (in_op[127:64]),
    .is64      (in_type == TY_I64),
    .is_zero   (i_zero),
    .mant      (i_mant),
    .exp_preset(i_exp)
  );

  logic [1:0]              fi;
  logic                    is_int;
  logic [MANT_W-1:0]       norm_in;
  logic signed [EXP_W-1:0] norm_ein;
  logic [MANT_W-1:0]       norm_out;
  logic signed [EXP_W-1:0] norm_eout;
  logic [6:0]              norm_shift;

  assign fi     = 2'(in_type - TY_SGL);
  assign is_int = (in_type == TY_I32) || (in_type == TY_I64);

  always_comb begin
    if (is_int || fi == 2'd3) begin
      norm_in  = i_mant;
      norm_ein = i_exp;
    end else begin
      norm_in  = f_al[fi];
      norm_ein = f_de[fi];
    end
  end

  fp_unpack_norm #(.MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)) u_norm (
    .mant_in (norm_in),
    .exp_in  (norm_ein),
    .mant_out(norm_out),
    .exp_out (norm_eout),
    .shift   (norm_shift)
  );

  // named events, observed by the bound checker
  logic                    use_norm;
  logic                    snan_evt;
  logic [2:0]              nx_cls;
  logic [MANT_W-1:0]       nx_mant;
  logic signed [EXP_W-1:0] nx_exp;
  logic                    nx_err;

  always_comb begin
    use_norm = 1'b0;
    snan_evt = 1'b0;
    nx_cls   = CLS_ZERO;
    nx_mant  = '0;
    nx_exp   = '0;
    nx_err   = 1'b0;
    case (in_type)
      TY_I32, TY_I64: begin
        if (!i_zero) begin
          use_norm = 1'b1;
          nx_cls   = CLS_NUM;
        end
      end
      TY_SGL, TY_DBL, TY_QUAD: begin
        if (f_ez[fi]) begin
          if (f_nz[fi]) begin
            use_norm = 1'b1;
            nx_cls   = CLS_NUM;
          end
        end else if (f_em[fi]) begin
          if (f_nz[fi]) begin
            nx_mant  = f_al[fi] | QBIT;
            snan_evt = !f_q[fi];
            nx_cls   = f_q[fi] ? CLS_QNAN : CLS_SNAN;
          end else begin
            nx_cls = CLS_INF;
          end
        end else begin
          nx_cls  = CLS_NUM;
          nx_mant = f_al[fi] | HBIT;
          nx_exp  = f_ue[fi];
        end
      end
      default: nx_err = 1'b1;
    endcase
    if (use_norm) begin
      nx_mant = norm_out;
      nx_exp  = norm_eout;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_sign     <= 1'b0;
      out_exp      <= '0;
      out_mant     <= '0;
      out_class    <= CLS_ZERO;
      out_invalid  <= 1'b0;
      out_type_err <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign     <= in_op[127];
        out_exp      <= nx_exp;
        out_mant     <= nx_mant;
        out_class    <= nx_cls;
        out_invalid  <= snan_evt;
        out_type_err <= nx_err;
      end
    end
  end
endmodule

// File: rtl/fp_unpack_chk.sv
module fp_unpack_chk #(
  parameter int MANT_W = 128,
  parameter int LEAD   = 114,
  parameter int EXP_W  = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [127:0]      in_op,
  input logic              snan_evt,
  input logic              use_norm,
  input logic [6:0]        norm_shift,
  input logic              out_valid,
  input logic              out_sign,
  input logic [EXP_W-1:0]  out_exp,
  input logic [MANT_W-1:0] out_mant,
  input logic [2:0]        out_class,
  input logic              out_invalid,
  input logic              out_type_err
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_mant) && $stable(out_class));
  assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_sign == $past(in_op[127]));
  assert_zero_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd0 |-> out_mant == '0 && out_exp == '0);
  assert_lead_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd1 |-> out_mant[LEAD] && out_mant[MANT_W-1:LEAD+1] == '0);
  assert_shift_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && use_norm |-> norm_shift <= 7'(LEAD));
  assert_inf_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 3'd2 |-> out_mant == '0);
  assert_nan_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == 3'd3 || out_class == 3'd4) |-> out_mant[LEAD-1] && !out_mant[LEAD]);
  assert_invalid_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_invalid == (out_class == 3'd4));
  assert_snan_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && snan_evt |=> out_invalid);
  assert_err_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_type_err |-> out_class == 3'd0 && out_mant == '0 && !out_invalid);
endmodule

bind fp_operand_unpack fp_unpack_chk #(.MANT_W(MANT_W), .LEAD(LEAD), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .snan_evt(snan_evt), .use_norm(use_norm), .norm_shift(norm_shift),
  .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
  .out_mant(out_mant), .out_class(out_class), .out_invalid(out_invalid),
  .out_type_err(out_type_err)
);

// File: tb/fp_operand_unpack_tb.sv
module fp_operand_unpack_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   in_type = '0;
  logic [127:0] in_op = '0;
  logic         out_valid, out_sign, out_invalid, out_type_err;
  logic [17:0]  out_exp;
  logic [127:0] out_mant;
  logic [2:0]   out_class;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  fp_operand_unpack u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type), .in_op(in_op),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant),
    .out_class(out_class), .out_invalid(out_invalid), .out_type_err(out_type_err)
  );

  typedef struct packed {
    logic         s;
    logic [2:0]   c;
    logic [17:0]  e;
    logic [127:0] m;
    logic         inv;
    logic         err;
  } res_t;

  function automatic res_t model(input logic [2:0] ty, input logic [127:0] op);
    res_t r;
    r = '0;
    r.s = op[127];
    if (ty <= 3'd1) begin
      logic [63:0] x, mag;
      int p;
      x   = (ty == 3'd0) ? {{32{op[127]}}, op[127:96]} : op[127:64];
      mag = x[63] ? (64'd0 - x) : x;
      if (mag != 0) begin
        p = 0;
        for (int b = 0; b < 64; b++) if (mag[b]) p = b;
        r.c = 3'd1;
        r.m = 128'(mag) << (114 - p);
        r.e = 18'(p);
      end
    end else if (ty <= 3'd4) begin
      int eb, fb, bias, ex;
      logic [127:0] fr, al;
      eb   = (ty == 3'd2) ? 8 : (ty == 3'd3) ? 11 : 15;
      fb   = (ty == 3'd2) ? 23 : (ty == 3'd3) ? 52 : 112;
      bias = (1 << (eb - 1)) - 1;
      ex   = int'((op << 1) >> (128 - eb));
      fr   = (op << (1 + eb)) & ~((128'd1 << (128 - fb)) - 128'd1);
      al   = fr >> 14;
      if (ex == 0) begin
        if (al != 0) begin
          int e;
          e = 1 - bias;
          while (!al[114]) begin al = al << 1; e = e - 1; end
          r.c = 3'd1; r.m = al; r.e = 18'(e);
        end
      end else if (ex == (1 << eb) - 1) begin
        if (al == 0) r.c = 3'd2;
        else begin
          r.c   = al[113] ? 3'd3 : 3'd4;
          r.inv = !al[113];
          r.m   = al | (128'd1 << 113);
        end
      end else begin
        r.c = 3'd1; r.m = al | (128'd1 << 114); r.e = 18'(ex - bias);
      end
    end else begin
      r.err = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [2:0] ty, input logic [127:0] op, input string tag);
    res_t r;
    r = model(ty, op);
    in_valid = 1'b1; in_type = ty; in_op = op;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "out_valid", 128'(out_valid), 128'd1);
    chk("R2", "sign", 128'(out_sign), 128'(r.s));
    chk(tag, "class", 128'(out_class), 128'(r.c));
    chk(tag, "exp", 128'(out_exp), 128'(r.e));
    chk(tag, "mant", out_mant, r.m);
    chk(tag, "invalid", 128'(out_invalid), 128'(r.inv));
    chk("R11", "type_err", 128'(out_type_err), 128'(r.err));
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R1", "out_valid idle", 128'(out_valid), 128'd0);
  endtask

  function automatic logic [127:0] gen(input logic [2:0] ty);
    logic [127:0] op, em, fm;
    int eb, fb, k;
    op = {$urandom, $urandom, $urandom, $urandom};
    k  = int'($urandom % 8);
    if (ty <= 3'd1) begin
      if (k == 0) op[127:64] = '0;
      else if (k == 1) op[127:64] = 64'($urandom % 300);
      else if (k == 2) op[127:96] = 32'h8000_0000;
    end else if (ty <= 3'd4) begin
      eb = (ty == 3'd2) ? 8 : (ty == 3'd3) ? 11 : 15;
      fb = (ty == 3'd2) ? 23 : (ty == 3'd3) ? 52 : 112;
      em = ((128'd1 << eb) - 128'd1) << (127 - eb);
      fm = ((128'd1 << fb) - 128'd1) << (127 - eb - fb);
      case (k)
        0: op = op & ~em;
        1: op = op | em;
        2: op = op & ~em & ~fm;
        3: op = (op | em) & ~fm;
        4: op = (op & ~em & ~fm) | (((op & fm) >> ($urandom % fb)) & fm);
        5: op = (op | em) & ~(128'd1 << (126 - eb));
        default: ;
      endcase
    end
    return op;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E_3D4C));
    repeat (3) @(negedge clk);
    // reset state
    chk("R1", "reset out_valid", 128'(out_valid), 128'd0);
    chk("R3", "reset class", 128'(out_class), 128'd0);
    chk("R3", "reset mant", out_mant, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_one(3'd0, 128'd0, "R3");                               idle_check();
    run_one(3'd0, {32'hFFFF_FFFF, 96'd0}, "R9");               idle_check();
    run_one(3'd0, {32'h8000_0000, 96'd0}, "R9");               idle_check();
    run_one(3'd0, {32'h0000_0001, 96'h5}, "R9");               idle_check();
    run_one(3'd1, {64'h0000_0000_0000_0001, 64'd0}, "R10");    idle_check();
    run_one(3'd1, {64'h8000_0000_0000_0000, 64'd0}, "R10");    idle_check();
    run_one(3'd1, {32'h0, 32'h8000_0000, 64'd0}, "R10");       idle_check();
    run_one(3'd2, {32'h3F80_0000, 96'd0}, "R4");               idle_check();
    run_one(3'd2, {32'h8000_0000, 96'd0}, "R3");               idle_check();
    run_one(3'd2, {32'h0000_0001, 96'd0}, "R5");               idle_check();
    run_one(3'd2, {32'h007F_FFFF, 96'd0}, "R5");               idle_check();
    run_one(3'd2, {32'hFF80_0000, 96'd0}, "R6");               idle_check();
    run_one(3'd2, {32'h7FC0_0000, 96'd0}, "R7");               idle_check();
    run_one(3'd2, {32'h7F80_0001, 96'd0}, "R8");               idle_check();
    run_one(3'd3, {64'h7FF0_0000_0000_0000, 64'd0}, "R6");     idle_check();
    run_one(3'd3, {64'h0000_0000_0000_0001, 64'd0}, "R5");     idle_check();
    run_one(3'd3, {64'h7FF4_0000_0000_0000, 64'd0}, "R8");     idle_check();
    run_one(3'd4, 128'd1, "R5");                               idle_check();
    run_one(3'd4, {16'h3FFF, 112'd0}, "R4");                   idle_check();
    run_one(3'd4, {16'h7FFF, 1'b1, 111'd0}, "R7");             idle_check();
    run_one(3'd5, {32'h3F80_0000, 96'd0}, "R11");              idle_check();
    run_one(3'd7, 128'd0, "R11");                              idle_check();

    for (int n = 0; n < 1500; n++) begin
      logic [2:0] ty;
      int pick;
      pick = int'($urandom % 10);
      ty = (pick <= 4) ? 3'(pick) : (pick == 9) ? 3'(5 + $urandom % 3) : 3'(pick - 5);
      run_one(ty, gen(ty), "R4");
    end
    idle_check();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule